// File: doc/BRIEF.md
# Completion-Acknowledged Paced Interrupt Controller

This block gathers per-queue "completion recorded" events from a set of descriptor engines. It presents them as one pending-status vector and one physical interrupt line. Each time an engine records a completion pointer for a queue, the block keeps that pointer and marks the queue pending.

Software services a queue and then acknowledges it by writing a pointer value back. The queue's pending bit is cleared only if that value equals the pointer the hardware last recorded for that queue. A stale acknowledge therefore cannot hide newer work.

The interrupt rate is limited by a countdown. Software reloads the countdown after servicing. The countdown steps down once per prescaled tick and stops at zero, and the line can only assert while it sits at zero. A reload value of zero disables pacing. A reload value wider than the countdown saturates to its largest value.

Top module: `cpl_irq_pacer`

## Requirements
- R1: After reset, status_o is all zero, irq_o is low, every stored pointer is zero and the countdown is zero.
- R2: A high hw_cp_wr[q] on a clock edge sets status_o[q] (bit index q) at that edge and stores hw_cp_val[q*PTR_W +: PTR_W] as queue q's pointer; several queues may be strobed on one edge.
- R3: A software acknowledge is sw_wr_en=1 with sw_wr_op=0 and the queue number on sw_wr_q. If sw_wr_data equals the pointer stored for that queue, status_o[q] clears at that edge.
- R4: An acknowledge whose data differs from the stored pointer leaves status_o[q] set, so irq_o stays or comes back high while the countdown is zero.
- R5: When hw_cp_wr[q] and a matching acknowledge for q fall on the same edge, status_o[q] stays set and the pointer takes the new hardware value.
- R6: irq_o is high exactly when at least one status_o bit is set and the countdown is zero.
- R7: A reload is sw_wr_en=1 with sw_wr_op=1. It loads the countdown from sw_wr_data and restarts the prescaler. The countdown then falls by one every TICK_DIV cycles and holds at zero, so a pending queue reaches irq_o exactly value×TICK_DIV edges after the reload edge.
- R8: A reload of zero (and the state after reset) applies no pacing: a pending bit appears on irq_o in the same cycle as the bit itself.
- R9: Writes with sw_wr_en low, or acknowledges naming another queue, leave status_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_cp_wr | input | NUM_Q | Per-queue hardware completion-pointer write strobe |
| hw_cp_val | input | NUM_Q*PTR_W | Per-queue pointer values, queue q in slice q*PTR_W |
| sw_wr_en | input | 1 | Software register write strobe |
| sw_wr_op | input | 1 | 0 = completion acknowledge, 1 = pacing reload |
| sw_wr_q | input | QW | Queue addressed by an acknowledge |
| sw_wr_data | input | PTR_W | Acknowledge pointer or reload value |
| status_o | output | NUM_Q | Pending status, one bit per queue |
| irq_o | output | 1 | Physical interrupt line |

## Verification
Status bits and stored pointers change on the edge that samples a strobe or acknowledge. irq_o follows from registered state with no extra delay. After a reload, the line returns exactly value×TICK_DIV edges later. The bench drives inputs on falling edges and compares against its behavioural model on the next falling edge, one full edge after every stimulus. The paced-return test counts eighteen further falling edges after the strobe that follows the reload and expects the line still low, then high one edge later.

// File: rtl/cpl_irq_pkg.sv
package cpl_irq_pkg;
   typedef enum logic {
      SW_OP_ACK    = 1'b0,
      SW_OP_RELOAD = 1'b1
   } sw_op_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/cpl_ptr_bank.sv
module cpl_ptr_bank #(
   parameter int NUM_Q = 16,
   parameter int PTR_W = 32,
   parameter int QW    = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_Q-1:0]       hw_wr,
   input  logic [NUM_Q*PTR_W-1:0] hw_val,
   input  logic                   ack_en,
   input  logic [QW-1:0]          ack_q,
   input  logic [PTR_W-1:0]       ack_data,
   output logic [NUM_Q*PTR_W-1:0] ptr_flat,
   output logic [NUM_Q-1:0]       ack_hit
);
   // One pointer register and one comparator per queue
   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      logic [PTR_W-1:0] ptr_r;

      always_ff @(posedge clk) begin
         if (!rst_n)
            ptr_r <= '0;
         else if (hw_wr[q])
            ptr_r <= hw_val[q*PTR_W +: PTR_W];
      end

      assign ptr_flat[q*PTR_W +: PTR_W] = ptr_r;
      assign ack_hit[q] = ack_en && (ack_q == QW'(q)) && (ack_data == ptr_r);
   end
endmodule

// File: rtl/cpl_pend_bank.sv
module cpl_pend_bank #(
   parameter int NUM_Q = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_Q-1:0] set_req,
   input  logic [NUM_Q-1:0] clr_req,
   output logic [NUM_Q-1:0] pend
);
   for (genvar q = 0; q < NUM_Q; q++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)
            pend[q] <= 1'b0;
         else if (set_req[q])
            pend[q] <= 1'b1;   // a fresh event outranks an acknowledge
         else if (clr_req[q])
            pend[q] <= 1'b0;
      end
   end
endmodule

// File: rtl/cpl_pace_timer.sv
module cpl_pace_timer #(
   parameter int CNT_W    = 16,
   parameter int VAL_W    = 32,
   parameter int TICK_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reload_en,
   input  logic [VAL_W-1:0] reload_val,
   output logic [CNT_W-1:0] count,
   output logic             expired
);
   logic             tick;
   logic [CNT_W-1:0] load_val;

   if (VAL_W > CNT_W) begin : g_sat
      always_comb
         load_val = (|reload_val[VAL_W-1:CNT_W]) ? '1 : reload_val[CNT_W-1:0];
   end else begin : g_direct
      always_comb load_val = reload_val;
   end

   if (TICK_DIV == 1) begin : g_noprescale
      assign tick = 1'b1;
   end else begin : g_prescale
      localparam int DW = $clog2(TICK_DIV);
      localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);
      logic [DW-1:0] div_r;

      always_ff @(posedge clk) begin
         if (!rst_n)
            div_r <= '0;
         else if (reload_en || div_r == DIV_LAST)
            div_r <= '0;
         else
            div_r <= div_r + 1'b1;
      end

      assign tick = (div_r == DIV_LAST);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (reload_en)
         count <= load_val;
      else if (tick && count != '0)
         count <= count - 1'b1;
   end

   assign expired = (count == '0);
endmodule

// File: rtl/cpl_irq_pacer.sv
module cpl_irq_pacer #(
   parameter int NUM_Q    = 16,
   parameter int PTR_W    = 32,
   parameter int CNT_W    = 16,
   parameter int TICK_DIV = 4,
   localparam int QW      = cpl_irq_pkg::idx_width(NUM_Q)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_Q-1:0]       hw_cp_wr,
   input  logic [NUM_Q*PTR_W-1:0] hw_cp_val,
   input  logic                   sw_wr_en,
   input  logic                   sw_wr_op,
   input  logic [QW-1:0]          sw_wr_q,
   input  logic [PTR_W-1:0]       sw_wr_data,
   output logic [NUM_Q-1:0]       status_o,
   output logic                   irq_o
);
   import cpl_irq_pkg::*;

   if (NUM_Q < 1 || NUM_Q > 16) begin : g_bad_nq
      $error("NUM_Q must lie in 1..16");
   end
   if (CNT_W < 1 || CNT_W > PTR_W) begin : g_bad_cw
      $error("CNT_W must lie in 1..PTR_W");
   end
   if (TICK_DIV < 1) begin : g_bad_div
      $error("TICK_DIV must be at least 1");
   end

   sw_op_e                 op;
   logic                   ack_en;
   logic                   reload_en;
   logic [NUM_Q-1:0]       ack_hit;
   logic [NUM_Q*PTR_W-1:0] ptr_flat;
   logic [CNT_W-1:0]       pace_cnt;
   logic                   pace_zero;

   assign op        = sw_op_e'(sw_wr_op);
   assign ack_en    = sw_wr_en && (op == SW_OP_ACK);
   assign reload_en = sw_wr_en && (op == SW_OP_RELOAD);

   cpl_ptr_bank #(.NUM_Q(NUM_Q), .PTR_W(PTR_W), .QW(QW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_wr    (hw_cp_wr),
      .hw_val   (hw_cp_val),
      .ack_en   (ack_en),
      .ack_q    (sw_wr_q),
      .ack_data (sw_wr_data),
      .ptr_flat (ptr_flat),
      .ack_hit  (ack_hit)
   );

   cpl_pend_bank #(.NUM_Q(NUM_Q)) u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (hw_cp_wr),
      .clr_req (ack_hit),
      .pend    (status_o)
   );

   cpl_pace_timer #(.CNT_W(CNT_W), .VAL_W(PTR_W), .TICK_DIV(TICK_DIV)) u_pace (
      .clk        (clk),
      .rst_n      (rst_n),
      .reload_en  (reload_en),
      .reload_val (sw_wr_data),
      .count      (pace_cnt),
      .expired    (pace_zero)
   );

   assign irq_o = (|status_o) && pace_zero;
endmodule

// File: rtl/cpl_irq_pacer_chk.sv
module cpl_irq_pacer_chk #(
   parameter int NUM_Q = 16,
   parameter int PTR_W = 32,
   parameter int CNT_W = 16,
   parameter int QW    = 4
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_Q-1:0]       hw_cp_wr,
   input logic                   sw_wr_en,
   input logic                   sw_wr_op,
   input logic [QW-1:0]          sw_wr_q,
   input logic [PTR_W-1:0]       sw_wr_data,
   input logic [NUM_Q-1:0]       status_o,
   input logic                   irq_o,
   input logic [NUM_Q*PTR_W-1:0] ptr_flat,
   input logic [CNT_W-1:0]       pace_cnt
);
   logic reload_req;
   assign reload_req = sw_wr_en && sw_wr_op;

   for (genvar q = 0; q < NUM_Q; q++) begin : g_q
      logic ack_match;
      assign ack_match = sw_wr_en && !sw_wr_op && (sw_wr_q == QW'(q))
                         && (sw_wr_data == ptr_flat[q*PTR_W +: PTR_W]);

      AST_HW_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
         hw_cp_wr[q] |=> status_o[q]); // R2
      AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_match && !hw_cp_wr[q]) |=> !status_o[q]); // R3
      AST_NOMATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         (status_o[q] && !ack_match) |=> status_o[q]); // R4
      AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_match && hw_cp_wr[q]) |=> status_o[q]); // R5
   end

   AST_IRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (|status_o)); // R6
   AST_IRQ_HELD_BY_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
      (pace_cnt != '0) |-> !irq_o); // R6
   AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req |=> (pace_cnt == $past(sw_wr_data[CNT_W-1:0]) || pace_cnt == '1)); // R7
   AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (pace_cnt == '0 && !reload_req) |=> (pace_cnt == '0)); // R7
   AST_CNT_NEVER_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      !reload_req |=> (pace_cnt <= $past(pace_cnt))); // R7
endmodule

bind cpl_irq_pacer cpl_irq_pacer_chk #(
   .NUM_Q (NUM_Q),
   .PTR_W (PTR_W),
   .CNT_W (CNT_W),
   .QW    (QW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hw_cp_wr   (hw_cp_wr),
   .sw_wr_en   (sw_wr_en),
   .sw_wr_op   (sw_wr_op),
   .sw_wr_q    (sw_wr_q),
   .sw_wr_data (sw_wr_data),
   .status_o   (status_o),
   .irq_o      (irq_o),
   .ptr_flat   (ptr_flat),
   .pace_cnt   (pace_cnt)
);

// File: tb/tb_cpl_irq_pacer.sv
`timescale 1ns/1ps
module tb_cpl_irq_pacer;
   localparam int NQ = 16;
   localparam int PW = 32;
   localparam int CW = 16;
   localparam int TD = 4;
   localparam int QW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic [NQ-1:0]    hw_cp_wr = '0;
   logic [NQ*PW-1:0] hw_cp_val = '0;
   logic             sw_wr_en = 1'b0;
   logic             sw_wr_op = 1'b0;
   logic [QW-1:0]    sw_wr_q = '0;
   logic [PW-1:0]    sw_wr_data = '0;
   logic [NQ-1:0]    status_o;
   logic             irq_o;

   cpl_irq_pacer #(.NUM_Q(NQ), .PTR_W(PW), .CNT_W(CW), .TICK_DIV(TD)) dut (
      .clk(clk), .rst_n(rst_n), .hw_cp_wr(hw_cp_wr), .hw_cp_val(hw_cp_val),
      .sw_wr_en(sw_wr_en), .sw_wr_op(sw_wr_op), .sw_wr_q(sw_wr_q),
      .sw_wr_data(sw_wr_data), .status_o(status_o), .irq_o(irq_o)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   logic [PW-1:0] m_ptr [NQ];
   bit            m_pend [NQ];
   int            m_cnt = 0;
   int            m_div = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int q = 0; q < NQ; q++) begin m_ptr[q] = '0; m_pend[q] = 0; end
         m_cnt = 0; m_div = 0;
      end else begin
         for (int q = 0; q < NQ; q++) begin
            if (hw_cp_wr[q]) m_pend[q] = 1;
            else if (sw_wr_en && !sw_wr_op && int'(sw_wr_q) == q && sw_wr_data == m_ptr[q])
               m_pend[q] = 0;
            if (hw_cp_wr[q]) m_ptr[q] = hw_cp_val[q*PW +: PW];
         end
         if (sw_wr_en && sw_wr_op) begin
            m_cnt = ((sw_wr_data >> CW) != 0) ? (1 << CW) - 1 : int'(sw_wr_data);
            m_div = 0;
         end else if (m_div == TD - 1) begin
            m_div = 0;
            if (m_cnt > 0) m_cnt--;
         end else begin
            m_div++;
         end
      end
   end

   function automatic logic [NQ-1:0] model_status();
      logic [NQ-1:0] v;
      for (int q = 0; q < NQ; q++) v[q] = m_pend[q];
      return v;
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         check(status_o == model_status(), "R2/R3 status vs model", status_o, model_status());
         check(irq_o == ((|model_status()) && m_cnt == 0), "R6 irq vs model",
               irq_o, (|model_status()) && m_cnt == 0);
      end
   end

   task automatic hw_write(input int q, input logic [PW-1:0] v);
      hw_cp_wr[q] = 1'b1;
      hw_cp_val[q*PW +: PW] = v;
      @(negedge clk);
      hw_cp_wr[q] = 1'b0;
   endtask

   task automatic sw_ack(input int q, input logic [PW-1:0] v);
      sw_wr_en = 1'b1; sw_wr_op = 1'b0; sw_wr_q = QW'(q); sw_wr_data = v;
      @(negedge clk);
      sw_wr_en = 1'b0;
   endtask

   task automatic sw_reload(input logic [PW-1:0] v);
      sw_wr_en = 1'b1; sw_wr_op = 1'b1; sw_wr_data = v;
      @(negedge clk);
      sw_wr_en = 1'b0; sw_wr_op = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(status_o == '0, "R1 reset status", status_o, 0);
      check(irq_o == 1'b0, "R1 reset irq", irq_o, 0);

      hw_write(3, 32'h1000);
      check(status_o == 16'h0008, "R2 set queue 3", status_o, 16'h0008);
      check(irq_o == 1'b1, "R8 no pacing after reset", irq_o, 1);

      sw_ack(3, 32'h0FFF);
      check(status_o == 16'h0008, "R4 mismatch keeps bit", status_o, 16'h0008);
      check(irq_o == 1'b1, "R4 irq still high", irq_o, 1);

      sw_ack(5, 32'h1000);
      check(status_o == 16'h0008, "R9 other queue ack", status_o, 16'h0008);

      sw_ack(3, 32'h1000);
      check(status_o == 16'h0000, "R3 match clears", status_o, 0);
      check(irq_o == 1'b0, "R6 irq low when idle", irq_o, 0);

      sw_reload(32'd5);
      hw_write(7, 32'hABC);
      repeat (18) @(negedge clk);
      check(irq_o == 1'b0, "R7 held off before 5*TD edges", irq_o, 0);
      @(negedge clk);
      check(irq_o == 1'b1, "R7 asserts at 5*TD edges", irq_o, 1);
      check(status_o == 16'h0080, "R2 queue 7 pending", status_o, 16'h0080);

      hw_cp_wr[7] = 1'b1; hw_cp_val[7*PW +: PW] = 32'h2000;
      sw_wr_en = 1'b1; sw_wr_op = 1'b0; sw_wr_q = 4'd7; sw_wr_data = 32'hABC;
      @(negedge clk);
      hw_cp_wr[7] = 1'b0; sw_wr_en = 1'b0;
      check(status_o[7] == 1'b1, "R5 set beats matching ack", status_o[7], 1);
      sw_ack(7, 32'hABC);
      check(status_o[7] == 1'b1, "R5 pointer took new value", status_o[7], 1);
      sw_ack(7, 32'h2000);
      check(status_o[7] == 1'b0, "R3 ack with new pointer", status_o[7], 0);

      hw_write(7, 32'h3000);
      sw_reload(32'd7);
      check(irq_o == 1'b0, "R7 reload restarts hold-off", irq_o, 0);
      sw_reload(32'd0);
      check(irq_o == 1'b1, "R8 zero reload no pacing", irq_o, 1);
      sw_ack(7, 32'h3000);

      hw_cp_wr = 16'h8001;
      hw_cp_val[0 +: PW] = 32'h11;
      hw_cp_val[15*PW +: PW] = 32'hFF;
      @(negedge clk);
      hw_cp_wr = '0;
      check(status_o == 16'h8001, "R2 two queues one edge", status_o, 16'h8001);
      sw_ack(15, 32'hFF);
      check(status_o == 16'h0001, "R3 clear queue 15", status_o, 16'h0001);

      sw_wr_en = 1'b0; sw_wr_op = 1'b0; sw_wr_q = 4'd0; sw_wr_data = 32'h11;
      @(negedge clk);
      check(status_o == 16'h0001, "R9 disabled write ignored", status_o, 16'h0001);
      sw_ack(0, 32'h11);
      check(status_o == 16'h0000, "R3 clear queue 0", status_o, 0);
      check(irq_o == 1'b0, "R6 irq low at end", irq_o, 0);

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule